// File: doc/BRIEF.md
# Capture/Compare Timer Unit

This block is a single general-purpose timer. A free-running 16-bit up-counter advances on ticks from an 8-bit prescaler. The prescaler counts either system clock cycles or rising edges of an external clock pin. In event-count mode, edges on the event pin advance the counter directly instead.

The same event pin also drives input capture. A selected edge on that pin copies the counter into a capture register. A programmable reference value is compared against the counter. When they match, the unit sets a status flag, can raise an interrupt, and can act on an output pin. The output pin action is either none, a pulse one prescaled tick long, or a toggle.

Software configures the unit through a small write port and reads it back through a combinational read port. A software enable bit freezes the counter, the prescaler and capture when cleared.

Top module: `gp_timer`

## Requirements
- R1: After reset the counter, capture register, status, control register, output pin and interrupt are all zero. Reads use `rd_addr` 0 = counter, 1 = capture, 2 = status in bits 1:0, 3 = control.
- R2: Writes use `wr_addr` 1 = prescale (bits 7:0) and 2 = reference (reset value 0xFFFF). Writes take effect at the clock edge where `wr_en` is high. With control bit 0 (enable) set and bit 1 (clock source) clear, the counter advances once every prescale+1 system clock cycles. Starting from a zero prescaler phase, it reads floor(m/(prescale+1)) m edges after the enabling write.
- R3: With control bit 3 (restart) clear, the counter passes 0xFFFF and wraps to 0.
- R4: With restart set, the counter reaches the reference value and then returns to 0 on its next tick instead of incrementing.
- R5: With control bit 1 set, the prescaler counts rising edges of `ext_clk` instead of system clock cycles. A pin edge reaches the prescaler on the third clock edge after it is sampled, because of a two-flop synchroniser.
- R6: With control bit 2 (event mode) set, the counter advances once per selected `evt_in` edge and ignores the prescaler.
- R7: On a selected `evt_in` edge, the capture register takes the counter value held just before the third clock edge after the pin change.
- R8: Control bits 7:6 select the event edge: 0 = none, 1 = rising, 2 = falling, 3 = both. An unselected edge neither captures nor counts.
- R9: Status bit 0 is set by a capture and status bit 1 by a reference match. Both are sticky and cleared by writing 1 to the same bit at `wr_addr` 3. A set in the same cycle as a clear wins.
- R10: `irq` is high while status bit 0 is set with control bit 8 set, or status bit 1 is set with control bit 9 set.
- R11: Control bits 5:4 choose the match action on `tmr_out`: 0 or 3 = none, 1 = high from the match until the next counter tick, 2 = toggle on each match.
- R12: With enable clear, the counter and prescaler hold their values and capture events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| ext_clk | input | 1 | External clock pin |
| evt_in | input | 1 | Capture / event pin |
| tmr_out | output | 1 | Match action output pin |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the edge inside the write strobe. Counter values are therefore predicted as floor(m/(prescale+1)) after m further edges, and they are sampled at the falling edge that follows. Pin changes on `ext_clk` and `evt_in` act on the third rising edge after they are driven. The bench reads the counter after the second edge to form the capture expectation, and reads the capture register after the third. Status and `irq` change on the same edge as the capture or match that causes them, so the bench samples them together with the counter each cycle. The set-beats-clear case places a status clear write exactly on that third edge.

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          ext_clk,
  input  logic          evt_in,
  output logic          tmr_out,
  output logic          irq
);
  localparam int CTW = 10;

  logic [CTW-1:0] ctrl_q;
  logic [PW-1:0]  psc_q, pre_q;
  logic [CW-1:0]  ref_q, cnt_q, cap_q, cnt_nxt;
  logic [1:0]     sts_q, sts_clr;
  logic [2:0]     ck_s, ev_s;
  logic           en, ext_sel, evt_mode, restart;
  logic [1:0]     omode, edge_sel;
  logic           ck_rise, ev_rise, ev_fall, ev_hit;
  logic           src_tick, pre_wrap, inc, ref_hit, cap_hit;

  assign en       = ctrl_q[0];
  assign ext_sel  = ctrl_q[1];
  assign evt_mode = ctrl_q[2];
  assign restart  = ctrl_q[3];
  assign omode    = ctrl_q[5:4];
  assign edge_sel = ctrl_q[7:6];

  assign ck_rise = ck_s[1] & ~ck_s[2];
  assign ev_rise = ev_s[1] & ~ev_s[2];
  assign ev_fall = ~ev_s[1] & ev_s[2];
  assign ev_hit  = (edge_sel[0] & ev_rise) | (edge_sel[1] & ev_fall);

  assign src_tick = ext_sel ? ck_rise : 1'b1;
  assign pre_wrap = (pre_q == psc_q);
  assign inc      = en & (evt_mode ? ev_hit : (src_tick & pre_wrap));
  assign cnt_nxt  = (restart && cnt_q == ref_q) ? '0 : cnt_q + 1'b1;
  assign ref_hit  = inc & (cnt_nxt == ref_q);
  assign cap_hit  = en & ev_hit;
  assign sts_clr  = (wr_en && wr_addr == 2'd3) ? wr_data[1:0] : 2'b00;

  assign irq = (sts_q[0] & ctrl_q[8]) | (sts_q[1] & ctrl_q[9]);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cnt_q;
      2'd1:    rd_data = cap_q;
      2'd2:    rd_data = CW'(sts_q);
      default: rd_data = CW'(ctrl_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s <= '0;
      ev_s <= '0;
    end else begin
      ck_s <= {ck_s[1:0], ext_clk};
      ev_s <= {ev_s[1:0], evt_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      ref_q  <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    ctrl_q <= wr_data[CTW-1:0];
        2'd1:    psc_q  <= wr_data[PW-1:0];
        2'd2:    ref_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (en && src_tick) begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (cap_hit) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else sts_q <= (sts_q & ~sts_clr) | {ref_hit, cap_hit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_out <= 1'b0;
    end else if (ref_hit) begin
      if (omode == 2'd1)      tmr_out <= 1'b1;
      else if (omode == 2'd2) tmr_out <= ~tmr_out;
    end else if (inc && omode == 2'd1) begin
      tmr_out <= 1'b0;
    end
  end
endmodule

module gp_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          en,
  input logic [1:0]    omode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic [1:0]    sts,
  input logic          tout,
  input logic          irq
);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0));

  a_r12_hold_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));

  a_r12_hold_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cap));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> sts[1]);

  a_r10_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != 2'b00));

  a_r11_none: assert property (@(posedge clk) disable iff (!rst_n)
    (omode == 2'd0) |=> $stable(tout));
endmodule

bind gp_timer gp_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .en(ctrl_q[0]), .omode(ctrl_q[5:4]),
  .cnt(cnt_q), .cap(cap_q), .sts(sts_q), .tout(tmr_out), .irq(irq)
);

// File: tb/gp_timer_tb.sv
`timescale 1ns/1ps
module gp_timer_tb;
  localparam logic [15:0] EN = 16'h0001, EXT = 16'h0002, EVT = 16'h0004,
    RST = 16'h0008, O_PUL = 16'h0010, O_TOG = 16'h0020,
    E_RISE = 16'h0040, E_FALL = 16'h0080, E_BOTH = 16'h00C0,
    CAP_IE = 16'h0100, REF_IE = 16'h0200;

  logic clk = 0, rst_n = 0, wr_en = 0, ext_clk = 0, evt_in = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic tmr_out, irq;
  int n_chk = 0, n_fail = 0;

  gp_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_clk(ext_clk), .evt_in(evt_in), .tmr_out(tmr_out), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; ext_clk = 0; evt_in = 0;
    step(2);
    rst_n = 1;
  endtask

  function automatic logic [15:0] exp_div(input int m, input int p);
    return 16'(m / (p + 1));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, ex;
    void'($urandom(32'd11));
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 read", v, 16'h0); end
    chk("R1 out", {15'b0, tmr_out}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 + R12 random prescale runs
    for (int it = 0; it < 20; it++) begin
      int p, n;
      p = int'($urandom % 16);
      n = 10 + int'($urandom % 300);
      do_reset();
      wr(2'd1, 16'(p));
      wr(2'd0, EN);
      step(n);
      rd(2'd0, v); chk("R2 prescaled count", v, exp_div(n, p));
      wr(2'd0, 16'h0);
      ex = exp_div(n + 1, p);
      step(5 + int'($urandom % 30));
      rd(2'd0, v); chk("R12 hold when disabled", v, ex);
    end

    // R4/R11 toggle with restart
    do_reset();
    wr(2'd1, 16'd1); wr(2'd2, 16'd3);
    wr(2'd0, EN | RST | O_TOG | REF_IE);
    for (int m = 1; m <= 40; m++) begin
      int hits;
      step(1);
      hits = (m >= 6) ? (m - 6) / 8 + 1 : 0;
      rd(2'd0, v); chk("R4 restart sequence", v, 16'((m / 2) % 4));
      chk("R11 toggle", {15'b0, tmr_out}, 16'(hits % 2));
      if (m == 6) begin
        rd(2'd2, v); chk("R9 ref status", v, 16'h2);
        chk("R10 irq on ref", {15'b0, irq}, 16'h1);
      end
    end
    wr(2'd3, 16'h2);
    rd(2'd2, v); chk("R9 w1c ref", v & 16'h2, 16'h0);

    // R11 pulse
    do_reset();
    wr(2'd1, 16'd1); wr(2'd2, 16'd3);
    wr(2'd0, EN | RST | O_PUL);
    for (int m = 1; m <= 32; m++) begin
      step(1);
      chk("R11 pulse", {15'b0, tmr_out}, 16'((m % 8) >= 6));
      if (m == 6) chk("R10 irq masked", {15'b0, irq}, 16'h0);
    end

    // R5 external clock source
    do_reset();
    wr(2'd1, 16'd1);
    wr(2'd0, EN | EXT);
    step(10);
    rd(2'd0, v); chk("R5 no sysclk count", v, 16'h0);
    for (int k = 0; k < 6; k++) begin ext_clk = 1; step(3); ext_clk = 0; step(3); end
    rd(2'd0, v); chk("R5 ext count", v, 16'd3);
    ext_clk = 1; step(2);
    ext_clk = 0;
    rd(2'd0, v); chk("R5 sync latency", v, 16'd3);
    step(1);
    rd(2'd0, v); chk("R5 sync latency", v, 16'd3);
    step(4);
    ext_clk = 1; step(2);
    rd(2'd0, v); chk("R5 before third edge", v, 16'd3);
    step(1);
    rd(2'd0, v); chk("R5 at third edge", v, 16'd4);
    ext_clk = 0; step(3);

    // R6 event count
    do_reset();
    wr(2'd0, EN | EVT | E_RISE);
    for (int k = 0; k < 5; k++) begin evt_in = 1; step(3); evt_in = 0; step(3); end
    rd(2'd0, v); chk("R6 event count", v, 16'd5);
    wr(2'd0, EN | EVT | E_BOTH);
    for (int k = 0; k < 3; k++) begin evt_in = 1; step(3); evt_in = 0; step(3); end
    rd(2'd0, v); chk("R6 both edges", v, 16'd11);

    // R7 R8 R9 R10 capture
    do_reset();
    wr(2'd1, 16'd9);
    wr(2'd0, EN | E_RISE | CAP_IE);
    step(25 + int'($urandom % 40));
    evt_in = 1; step(2);
    rd(2'd0, ex); step(1);
    rd(2'd1, v); chk("R7 capture value", v, ex);
    rd(2'd2, v); chk("R9 cap status", v, 16'h1);
    chk("R10 irq on cap", {15'b0, irq}, 16'h1);
    wr(2'd3, 16'h1);
    rd(2'd2, v); chk("R9 w1c cap", v, 16'h0);
    chk("R10 irq cleared", {15'b0, irq}, 16'h0);
    evt_in = 0; step(4);
    rd(2'd1, v); chk("R8 fall ignored on rise select", v, ex);
    rd(2'd2, v); chk("R8 no status on fall", v, 16'h0);

    wr(2'd0, EN | E_FALL);
    evt_in = 1; step(4);
    rd(2'd2, v); chk("R8 rise ignored on fall select", v, 16'h0);
    evt_in = 0; step(2);
    rd(2'd0, ex); step(1);
    rd(2'd1, v); chk("R7 capture on fall", v, ex);
    rd(2'd2, v); chk("R9 cap status fall", v, 16'h1);
    chk("R10 irq masked cap", {15'b0, irq}, 16'h0);
    wr(2'd3, 16'h1);

    wr(2'd0, EN);
    evt_in = 1; step(4); evt_in = 0; step(4);
    rd(2'd2, v); chk("R8 edge select none", v, 16'h0);

    // R9 set beats clear
    wr(2'd0, EN | E_BOTH);
    evt_in = 1; step(2);
    wr(2'd3, 16'h1);
    rd(2'd2, v); chk("R9 set wins over clear", v, 16'h1);
    wr(2'd3, 16'h1);
    evt_in = 0; step(4);
    wr(2'd3, 16'h1);

    // R12 capture ignored while disabled
    wr(2'd0, E_BOTH);
    rd(2'd1, ex);
    evt_in = 1; step(4); evt_in = 0; step(4);
    rd(2'd1, v); chk("R12 no capture disabled", v, ex);
    rd(2'd2, v); chk("R12 no status disabled", v, 16'h0);

    // R3 wrap
    do_reset();
    wr(2'd0, EN);
    step(65535);
    rd(2'd0, v); chk("R3 reaches max", v, 16'hFFFF);
    rd(2'd2, v); chk("R9 ref match at max", v, 16'h2);
    step(1);
    rd(2'd0, v); chk("R3 wrap to zero", v, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule